// File: doc/BRIEF.md
# Bus Activity Monitor with Consecutive-Breach Watermarks

This block watches one or more bus activity sources. Each source is a single-cycle pulse input, and each pulse counts as one unit of recorded activity. A single shared timer divides time into sampling periods. In every period, each channel adds a programmable weight per pulse to a running count. At the end of the period the channel folds that count into an exponential moving average. It then checks two things: the period count against an upper and a lower watermark, and the new average against a separate pair of average watermarks.

An interrupt status bit is set when a count stays beyond a count watermark for a programmed number of consecutive periods. A status bit is also set when the average crosses an average watermark. Firmware programs all of this through a small write and read register port. A global page holds the sampling period and a per-channel pending summary. The `irq` output combines the pending state of all channels.

Top module: `actmon_top`

## Requirements
- R1: Reset clears every register to zero and holds `irq` low. A read of any address returns zero while reset is active and right after it.
- R2: The period register sits at global offset 0x004 and holds P in bits [7:0]. A sampling period ends every (P+1)*CYC_PER_UNIT cycles. Writing the register restarts the timer, so the next period end comes (P+1)*CYC_PER_UNIT cycles after the write.
- R3: While channel enable (control bit 31) is set, each cycle with a pulse adds the count weight (offset 0x18) to the period count, saturating at 2^32-1. When a period ends, the count restarts from the current cycle's contribution.
- R4: With periodic sampling (control bit 18) also set, the average is updated at each period end as avg + ((count - avg) >>> (K+1)), using signed arithmetic. K is control bits [12:10]. The average reads at offset 0x20. A write to offset 0x0C loads the average directly and wins over a same-cycle update.
- R5: If the period count exceeds the upper watermark (offset 0x04) for N+1 consecutive periods, where N is control bits [28:26], the channel sets status bit 31. This happens only when control bit 30 is set. The run counter then restarts from zero.
- R6: If the period count is below the lower watermark (offset 0x08) for M+1 consecutive periods, where M is control bits [25:23], the channel sets status bit 30. This happens only when control bit 29 is set.
- R7: A period whose count does not breach a watermark resets that watermark's run of consecutive breaches to zero.
- R8: At a period end, if the new average is above the average upper watermark (offset 0x10) and control bit 21 is set, status bit 29 is set. If the new average is below the average lower watermark (offset 0x14) and control bit 20 is set, status bit 28 is set.
- R9: While control bit 31 is clear, the channel keeps its count and run counters at zero and sets no status bits. Writing zero to the control word (offset 0x00) stops the channel. With bit 31 set but bit 18 clear, the channel counts but neither samples nor sets flags.
- R10: The status register (offset 0x24, bits [31:28]) is write-one-to-clear, so writing all ones clears it. A bit set by hardware in the same cycle as a clear stays set.
- R11: The global status at offset 0x000 shows channel i's pending state (any status bit set) in bit i. `irq` is the OR of all pending bits. Channel i's registers occupy the page whose address bits [11:8] equal i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_pulse | input | NCH | Activity pulse per channel, one unit per high cycle |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | 32 | Read data, combinational from `reg_raddr` |
| irq | output | 1 | OR of all channel pending bits |

## Verification
The bench drives pulse rates that land above, inside and below the count watermarks. This checks that a run of breaches fires only on the (N+1)-th period and restarts after an in-band period. A design that counted runs off by one would raise the flag a period early or late. A design that failed to reset the run would fire on breaches that are not consecutive.

The bench loads the average with a value far above the count. This exercises the negative-difference arithmetic shift. A design using an unsigned shift would make the average jump upward instead of decaying.

The bench also stops a channel while pulses continue, runs a channel enabled without periodic sampling, and clears status. A design that kept counting when stopped, or that cleared status on a control write, would show a different status or `irq` value.

The bench rewrites the period in mid-run to a shorter value. A timer that failed to restart on that write would end the next period too early or too late.

// File: rtl/actmon_pkg.sv
package actmon_pkg;
  localparam int DATA_W = 32;
  localparam int RUN_W  = 3;

  // control word field positions (decoded by the channel)
  localparam int CTL_K_LSB      = 10;
  localparam int CTL_PERIODIC   = 18;
  localparam int CTL_AVG_LO_EN  = 20;
  localparam int CTL_AVG_HI_EN  = 21;
  localparam int CTL_LO_NUM_LSB = 23;
  localparam int CTL_HI_NUM_LSB = 26;
  localparam int CTL_LO_EN      = 29;
  localparam int CTL_HI_EN      = 30;
  localparam int CTL_ENABLE     = 31;

  // status flag positions
  localparam int ST_LSB = 28;   // flags occupy [31:28]

  typedef logic [7:0] ofs_t;
  localparam ofs_t OFS_CTRL   = 8'h00;
  localparam ofs_t OFS_UWM    = 8'h04;
  localparam ofs_t OFS_LWM    = 8'h08;
  localparam ofs_t OFS_INIT   = 8'h0C;
  localparam ofs_t OFS_AUWM   = 8'h10;
  localparam ofs_t OFS_ALWM   = 8'h14;
  localparam ofs_t OFS_WEIGHT = 8'h18;
  localparam ofs_t OFS_AVG    = 8'h20;
  localparam ofs_t OFS_STAT   = 8'h24;

  localparam ofs_t OFS_GSTAT  = 8'h00;
  localparam ofs_t OFS_PERIOD = 8'h04;
endpackage

// File: rtl/actmon_timer.sv
module actmon_timer #(
  parameter int CYC_PER_UNIT = 1000,
  parameter int PER_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_we,
  input  logic [PER_W-1:0] period_wdata,
  output logic [PER_W-1:0] period_q,
  output logic             tick
);
  localparam int CW = (CYC_PER_UNIT > 1) ? $clog2(CYC_PER_UNIT) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(CYC_PER_UNIT - 1);

  logic [CW-1:0]    cyc_q, cyc_d;
  logic [PER_W-1:0] unit_q, unit_d, period_d;
  logic             unit_end;

  always_comb begin
    unit_end = (cyc_q == CYC_LAST);
    tick     = unit_end && (unit_q == period_q);
    cyc_d    = unit_end ? '0 : cyc_q + 1'b1;
    if (tick)          unit_d = '0;
    else if (unit_end) unit_d = unit_q + 1'b1;
    else               unit_d = unit_q;
    period_d = period_q;
    if (period_we) begin
      period_d = period_wdata;
      cyc_d    = '0;
      unit_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q    <= '0;
      unit_q   <= '0;
      period_q <= '0;
    end else begin
      cyc_q    <= cyc_d;
      unit_q   <= unit_d;
      period_q <= period_d;
    end
  end
endmodule

// File: rtl/actmon_streak.sv
module actmon_streak #(
  parameter int NUM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sample,
  input  logic             hit,
  input  logic [NUM_W-1:0] limit,
  output logic             fire
);
  logic [NUM_W-1:0] run_q, run_d;

  always_comb begin
    fire  = sample && hit && (run_q == limit);
    run_d = run_q;
    if (clr)                 run_d = '0;
    else if (sample) begin
      if (!hit)              run_d = '0;
      else if (fire)         run_d = '0;
      else                   run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/actmon_chan.sv
module actmon_chan
  import actmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pulse,
  input  logic              wr_en,
  input  ofs_t              wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  ofs_t              rd_ofs,
  output logic [DATA_W-1:0] rd_data,
  output logic              pending
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d, uwm_q, uwm_d, lwm_q, lwm_d;
  logic [DATA_W-1:0] auwm_q, auwm_d, alwm_q, alwm_d, wgt_q, wgt_d;
  logic [DATA_W-1:0] avg_q, avg_d, cnt_q, cnt_d;
  logic [3:0]        stat_q, stat_d, stat_set, stat_clr;
  logic [DATA_W-1:0] add, cnt_sat, avg_new;
  logic [DATA_W:0]   sum;
  logic signed [DATA_W+1:0] diff, step;
  logic [3:0]        shamt;
  logic              en, sample, hi_hit, lo_hit, hi_fire, lo_fire;

  assign en     = ctrl_q[CTL_ENABLE];
  assign sample = en && ctrl_q[CTL_PERIODIC] && tick;
  assign hi_hit = cnt_q > uwm_q;
  assign lo_hit = cnt_q < lwm_q;

  actmon_streak #(.NUM_W(RUN_W)) u_hi_run (
    .clk(clk), .rst_n(rst_n), .clr(!en), .sample(sample), .hit(hi_hit),
    .limit(ctrl_q[CTL_HI_NUM_LSB +: RUN_W]), .fire(hi_fire)
  );

  actmon_streak #(.NUM_W(RUN_W)) u_lo_run (
    .clk(clk), .rst_n(rst_n), .clr(!en), .sample(sample), .hit(lo_hit),
    .limit(ctrl_q[CTL_LO_NUM_LSB +: RUN_W]), .fire(lo_fire)
  );

  // datapath: weighted count and moving average
  always_comb begin
    add     = pulse ? wgt_q : '0;
    sum     = {1'b0, cnt_q} + {1'b0, add};
    cnt_sat = sum[DATA_W] ? '1 : sum[DATA_W-1:0];
    shamt   = {1'b0, ctrl_q[CTL_K_LSB +: 3]} + 4'd1;
    diff    = $signed({2'b00, cnt_q}) - $signed({2'b00, avg_q});
    step    = diff >>> shamt;
    avg_new = DATA_W'($signed({2'b00, avg_q}) + step);
  end

  // next state
  always_comb begin
    ctrl_d = ctrl_q; uwm_d = uwm_q; lwm_d = lwm_q;
    auwm_d = auwm_q; alwm_d = alwm_q; wgt_d = wgt_q;

    if (!en)         cnt_d = '0;
    else if (sample) cnt_d = add;
    else             cnt_d = cnt_sat;

    avg_d = sample ? avg_new : avg_q;

    stat_set = {hi_fire & ctrl_q[CTL_HI_EN],
                lo_fire & ctrl_q[CTL_LO_EN],
                sample & (avg_new > auwm_q) & ctrl_q[CTL_AVG_HI_EN],
                sample & (avg_new < alwm_q) & ctrl_q[CTL_AVG_LO_EN]};
    stat_clr = '0;

    if (wr_en) begin
      unique case (wr_ofs)
        OFS_CTRL:   ctrl_d   = wr_data;
        OFS_UWM:    uwm_d    = wr_data;
        OFS_LWM:    lwm_d    = wr_data;
        OFS_INIT:   avg_d    = wr_data;
        OFS_AUWM:   auwm_d   = wr_data;
        OFS_ALWM:   alwm_d   = wr_data;
        OFS_WEIGHT: wgt_d    = wr_data;
        OFS_STAT:   stat_clr = wr_data[ST_LSB +: 4];
        default: ;
      endcase
    end
    stat_d = (stat_q & ~stat_clr) | stat_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; uwm_q <= '0; lwm_q <= '0; auwm_q <= '0; alwm_q <= '0;
      wgt_q  <= '0; avg_q <= '0; cnt_q <= '0; stat_q <= '0;
    end else begin
      ctrl_q <= ctrl_d; uwm_q <= uwm_d; lwm_q <= lwm_d; auwm_q <= auwm_d;
      alwm_q <= alwm_d; wgt_q <= wgt_d; avg_q <= avg_d; cnt_q <= cnt_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    unique case (rd_ofs)
      OFS_CTRL:   rd_data = ctrl_q;
      OFS_UWM:    rd_data = uwm_q;
      OFS_LWM:    rd_data = lwm_q;
      OFS_AUWM:   rd_data = auwm_q;
      OFS_ALWM:   rd_data = alwm_q;
      OFS_WEIGHT: rd_data = wgt_q;
      OFS_AVG:    rd_data = avg_q;
      OFS_STAT:   rd_data = {stat_q, {ST_LSB{1'b0}}};
      default:    rd_data = '0;
    endcase
  end

  assign pending = |stat_q;
endmodule

// File: rtl/actmon_top.sv
module actmon_top
  import actmon_pkg::*;
#(
  parameter int NCH          = 2,
  parameter int CYC_PER_UNIT = 1000,
  parameter int ADDR_W       = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    act_pulse,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int PW    = ADDR_W - 8;
  localparam int PER_W = 8;

  logic [PW-1:0]              page_w, page_r;
  ofs_t                       ofs_w, ofs_r;
  logic                       period_we, tick;
  logic [PER_W-1:0]           period_q;
  logic [NCH-1:0]             pend, ch_we;
  logic [NCH-1:0][DATA_W-1:0] ch_rdata;

  assign page_w    = reg_waddr[ADDR_W-1:8];
  assign ofs_w     = reg_waddr[7:0];
  assign page_r    = reg_raddr[ADDR_W-1:8];
  assign ofs_r     = reg_raddr[7:0];
  assign period_we = reg_we && (page_w == '0) && (ofs_w == OFS_PERIOD);

  actmon_timer #(.CYC_PER_UNIT(CYC_PER_UNIT), .PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period_we(period_we),
    .period_wdata(reg_wdata[PER_W-1:0]), .period_q(period_q), .tick(tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_we[g] = reg_we && (page_w == PW'(g + 1));
    actmon_chan u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pulse(act_pulse[g]),
      .wr_en(ch_we[g]), .wr_ofs(ofs_w), .wr_data(reg_wdata),
      .rd_ofs(ofs_r), .rd_data(ch_rdata[g]), .pending(pend[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (page_r == '0) begin
      if (ofs_r == OFS_GSTAT)       reg_rdata = DATA_W'(pend);
      else if (ofs_r == OFS_PERIOD) reg_rdata = DATA_W'(period_q);
    end else begin
      for (int i = 0; i < NCH; i++)
        if (page_r == PW'(i + 1)) reg_rdata = ch_rdata[i];
    end
  end

  assign irq = |pend;
endmodule

// File: rtl/actmon_top_chk.sv
module actmon_top_chk #(
  parameter int NCH          = 2,
  parameter int CYC_PER_UNIT = 1000,
  parameter int ADDR_W       = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_waddr,
  input logic [3:0]        clr_bits,
  input logic              tick,
  input logic              period_we,
  input logic [NCH-1:0]    pend
);
  localparam int PW = ADDR_W - 8;

  for (genvar g = 0; g < NCH; g++) begin : g_c
    logic stat_wr;
    assign stat_wr = reg_we && (reg_waddr == {PW'(g + 1), 8'h24});

    // R10: all-ones clear empties status when no period ends alongside
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && (&clr_bits) && !tick) |=> !pend[g]);

    // R10: pending is sticky until status is written
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[g] && !stat_wr) |=> pend[g]);

    // R2: flags only appear after a period end
    p_flag_at_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[g]) |-> $past(tick));
  end

  if (CYC_PER_UNIT > 1) begin : g_gap
    // R2: a period write restarts the timer
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      period_we |=> !tick);
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end
endmodule

bind actmon_top actmon_top_chk #(.NCH(NCH), .CYC_PER_UNIT(CYC_PER_UNIT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
  .clr_bits(reg_wdata[31:28]), .tick(tick), .period_we(period_we), .pend(pend)
);

// File: tb/sim_actmon_top.sv
module sim_actmon_top;
  localparam int NCH = 2;
  localparam int CYC = 4;
  localparam longint MSK = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NCH-1:0] act_pulse = '0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [11:0] reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  actmon_top #(.NCH(NCH), .CYC_PER_UNIT(CYC), .ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .act_pulse(act_pulse), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0, divs[NCH];
  bit done = 0;
  string phase = "R1";

  // reference model state
  longint m_per, m_cyc, m_unit;
  longint m_ctrl[NCH], m_uw[NCH], m_lw[NCH], m_au[NCH], m_al[NCH], m_wt[NCH];
  longint m_avg[NCH], m_cnt[NCH], m_st[NCH], m_hrun[NCH], m_lrun[NCH];

  function automatic longint bitf(longint v, int lsb, int w);
    return (v >> lsb) & ((64'd1 << w) - 1);
  endfunction

  task automatic model_reset();
    m_per = 0; m_cyc = 0; m_unit = 0;
    for (int c = 0; c < NCH; c++) begin
      m_ctrl[c] = 0; m_uw[c] = 0; m_lw[c] = 0; m_au[c] = 0; m_al[c] = 0;
      m_wt[c] = 0; m_avg[c] = 0; m_cnt[c] = 0; m_st[c] = 0; m_hrun[c] = 0; m_lrun[c] = 0;
    end
  endtask

  task automatic model_step();
    bit tk;
    tk = (m_cyc == CYC - 1) && (m_unit == m_per);
    if (m_cyc == CYC - 1) begin m_cyc = 0; m_unit = tk ? 0 : m_unit + 1; end
    else m_cyc++;
    if (reg_we && reg_waddr == 12'h004) begin
      m_per = reg_wdata & 255; m_cyc = 0; m_unit = 0;
    end
    for (int c = 0; c < NCH; c++) begin
      longint cr, add, navg, setb, clrb, diff;
      bit en, smp, hi, lo;
      cr = m_ctrl[c];
      en = bitf(cr, 31, 1) != 0;
      smp = en && bitf(cr, 18, 1) != 0 && tk;
      add = act_pulse[c] ? m_wt[c] : 0;
      setb = 0; navg = m_avg[c];
      if (smp) begin
        diff = m_cnt[c] - m_avg[c];
        navg = (m_avg[c] + (diff >>> (bitf(cr, 10, 3) + 1))) & MSK;
        hi = m_cnt[c] > m_uw[c];
        lo = m_cnt[c] < m_lw[c];
        if (hi && m_hrun[c] == bitf(cr, 26, 3)) begin
          m_hrun[c] = 0; if (bitf(cr, 30, 1) != 0) setb |= 64'h8000_0000;
        end else m_hrun[c] = hi ? (m_hrun[c] + 1) & 7 : 0;
        if (lo && m_lrun[c] == bitf(cr, 23, 3)) begin
          m_lrun[c] = 0; if (bitf(cr, 29, 1) != 0) setb |= 64'h4000_0000;
        end else m_lrun[c] = lo ? (m_lrun[c] + 1) & 7 : 0;
        if (navg > m_au[c] && bitf(cr, 21, 1) != 0) setb |= 64'h2000_0000;
        if (navg < m_al[c] && bitf(cr, 20, 1) != 0) setb |= 64'h1000_0000;
      end
      if (!en) begin m_cnt[c] = 0; m_hrun[c] = 0; m_lrun[c] = 0; end
      else if (smp) m_cnt[c] = add;
      else m_cnt[c] = (m_cnt[c] + add > MSK) ? MSK : m_cnt[c] + add;
      m_avg[c] = navg;
      clrb = 0;
      if (reg_we && reg_waddr[11:8] == 4'(c + 1)) begin
        case (reg_waddr[7:0])
          8'h00: m_ctrl[c] = reg_wdata;
          8'h04: m_uw[c] = reg_wdata;
          8'h08: m_lw[c] = reg_wdata;
          8'h0C: m_avg[c] = reg_wdata;
          8'h10: m_au[c] = reg_wdata;
          8'h14: m_al[c] = reg_wdata;
          8'h18: m_wt[c] = reg_wdata;
          8'h24: clrb = reg_wdata & 64'hF000_0000;
          default: ;
        endcase
      end
      m_st[c] = (m_st[c] & ~clrb) | setb;
    end
  endtask

  function automatic longint model_read(logic [11:0] a);
    longint r;
    r = 0;
    if (a[11:8] == 0) begin
      if (a[7:0] == 8'h00) for (int c = 0; c < NCH; c++) if (m_st[c] != 0) r |= (64'd1 << c);
      if (a[7:0] == 8'h04) r = m_per;
    end else begin
      for (int c = 0; c < NCH; c++) if (a[11:8] == 4'(c + 1)) begin
        case (a[7:0])
          8'h00: r = m_ctrl[c];
          8'h04: r = m_uw[c];
          8'h08: r = m_lw[c];
          8'h10: r = m_au[c];
          8'h14: r = m_al[c];
          8'h18: r = m_wt[c];
          8'h20: r = m_avg[c];
          8'h24: r = m_st[c];
          default: r = 0;
        endcase
      end
    end
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // model and compare on every clock
  always @(posedge clk) begin
    longint er;
    bit ei;
    if (!rst_n) model_reset(); else model_step();
    cycles++;
    #5;
    er = model_read(reg_raddr);
    ei = 0;
    for (int c = 0; c < NCH; c++) if (m_st[c] != 0) ei = 1;
    vectors++;
    if (longint'(reg_rdata) != er || irq !== ei) begin
      fails++;
      $display("FAIL %s: addr %h rdata %h expected %h, irq %b expected %b",
               phase, reg_raddr, reg_rdata, er[31:0], irq, ei);
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog in %s: actual timeout expected completion", phase);
      finish_run();
    end
  end

  // stimulus on the falling edge: pulses and rotating read address
  logic [11:0] rot [8] = '{12'h124, 12'h120, 12'h000, 12'h224,
                           12'h220, 12'h100, 12'h004, 12'h200};
  int ncyc = 0;
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++)
      act_pulse[c] <= (divs[c] != 0) && (ncyc % divs[c] == 0);
    reg_raddr <= rot[ncyc % 8];
    ncyc++;
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [31:0] EN = 32'h8000_0000, PERI = 32'h0004_0000;

  initial begin
    divs[0] = 0; divs[1] = 0;
    phase = "R1";
    run(4);
    rst_n = 1'b1;
    run(3);
    phase = "R2";
    wr(12'h004, 32'd2);
    run(12);
    phase = "R3";
    wr(12'h118, 32'd3);
    wr(12'h104, 32'd20);
    wr(12'h108, 32'd6);
    wr(12'h110, 32'd30);
    wr(12'h114, 32'd2);
    wr(12'h100, EN | PERI | 32'h4000_0000 | 32'h2000_0000 | (32'd1 << 26) |
                (32'd2 << 23) | (32'd1 << 21) | (32'd1 << 20) | (32'd1 << 10));
    divs[0] = 2;
    run(48);
    phase = "R4";
    wr(12'h10C, 32'd100);
    run(36);
    phase = "R10";
    wr(12'h124, 32'hFFFF_FFFF);
    run(12);
    phase = "R5";
    divs[0] = 1;
    run(48);
    phase = "R10";
    wr(12'h124, 32'hFFFF_FFFF);
    run(3);
    phase = "R7";
    for (int i = 0; i < 4; i++) begin
      divs[0] = 1; run(12);
      divs[0] = 2; run(12);
    end
    phase = "R6";
    wr(12'h124, 32'hFFFF_FFFF);
    divs[0] = 0;
    run(60);
    phase = "R8";
    wr(12'h124, 32'hFFFF_FFFF);
    divs[0] = 1;
    run(72);
    phase = "R9";
    wr(12'h100, 32'd0);
    wr(12'h124, 32'hFFFF_FFFF);
    divs[1] = 1;
    run(36);
    wr(12'h100, EN | 32'h4000_0000 | (32'd1 << 21));
    run(36);
    phase = "R11";
    wr(12'h218, 32'd1);
    wr(12'h208, 32'd5);
    wr(12'h20C, 32'd7);
    divs[1] = 0;
    wr(12'h200, EN | PERI | 32'h2000_0000);
    run(30);
    phase = "R2";
    wr(12'h004, 32'd0);
    divs[0] = 3;
    wr(12'h100, EN | PERI | 32'h4000_0000);
    run(40);
    finish_run();
  end
endmodule